// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block translates a 32-bit virtual address into a physical address by walking an in-memory translation tree. The walk begins in a context table. The base of that table comes from a root-pointer input, and the slot within it comes from a context-number input. From there the walk descends through as many as three indexed levels. Each step reads one 32-bit descriptor over a single-outstanding memory port. The descriptor's two low bits say whether it points to a further table, maps a page, is invalid, or is reserved.

A leaf descriptor found at level 1, 2 or 3 maps a page of 16 MB, 256 KB or 4 KB. The walker reports several things from the leaf:
- the physical address;
- the leaf level, which encodes the page size;
- the leaf's 3-bit permission field.

A failed walk reports a fault code instead. That code packs the fault type together with the level at which the walk stopped.

Permission evaluation happens outside the block. It returns a single `perm_ok` bit. When that bit is set and the leaf's accessed flag (or, for a write, its modified flag) is still clear, the walker sets the missing flags and stores the descriptor back to the address it was read from.

Top module: `ptw_walker`

## Requirements
- R1: The first read of a walk goes to address `(root_ptr << 4) + (ctx_num << 2)`; that read is level 0.
- R2: A descriptor whose low bits are 1 (pointer) at level n < 3 leads to a read at `({desc[31:2],2'b00} << 4) + 4*idx`, where idx is `va[31:24]` for level 1, `va[23:18]` for level 2, and `va[17:12]` for level 3.
- R3: A descriptor whose low bits are 2 (leaf) at level 1, 2 or 3 ends the walk with `fault = 0` and `leaf_lvl` equal to that level. `pa` is `desc[31:8] << 12` plus an offset: `va[23:12] << 12` at level 1, `va[17:12] << 12` at level 2, and 0 at level 3.
- R4: A descriptor whose low bits are 0 ends the walk with fault type 1. Every fault code has the form `{lvl[1:0], 3'b000, type[2:0], 2'b00}`, where lvl is the level of the failing read.
- R5: The walk ends with fault type 4 on any of these: low bits 3 at any level, a leaf found in the context table, or a pointer found at level 3.
- R6: A read answered with `mem_err` ends the walk with fault type 4 at the level of that read.
- R7: After a leaf, with `perm_ok` high, the walker writes the descriptor back to the same address if either of two conditions holds: bit 5 (accessed) is clear, or the access is a write and bit 6 (modified) is clear. The write sets bit 5, and also sets bit 6 for a write.
- R8: No write-back is issued when `perm_ok` is low, or when the flags that R7 would set are already set.
- R9: At most one memory transaction is outstanding. `mem_req`, `mem_we` and `mem_addr` hold steady until `mem_ack`.
- R10: `busy` rises the cycle after an accepted `start` and falls together with a one-cycle `done` pulse. A `start` while busy is ignored.
- R11: `leaf_perm` shows bits [4:2] of the leaf descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (taken when idle) |
| va | input | 32 | Virtual address to translate |
| is_write | input | 1 | Access is a store |
| root_ptr | input | 32 | Root pointer of the context table |
| ctx_num | input | CTXW | Context number |
| perm_ok | input | 1 | External permission check passed for the leaf |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | PAW | Descriptor address |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Memory response |
| mem_err | input | 1 | Bus error on the response |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| pa | output | PAW | Translated physical address |
| leaf_lvl | output | 2 | Level of the leaf (1: 16 MB, 2: 256 KB, 3: 4 KB) |
| leaf_perm | output | 3 | Permission field of the leaf |
| fault | output | 10 | Fault code, zero on success |

## Verification
A wrong level counter or a bad index select shows up directly on `mem_addr`, on the very next read after the descriptor that caused it. Such an error therefore also shifts the level field of any later fault code. A corrupted descriptor register shows up in `pa` and `leaf_perm` at the `done` pulse. It also shows up on the write-back data one cycle earlier. A stuck state machine shows as a `busy` that never falls, or as a second `done`, or as extra transactions per walk, so the bench counts reads, writes and completion pulses for every scenario.

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int PAW      = 36,
  parameter int CTXW     = 8,
  parameter int ACC_BIT  = 5,
  parameter int MOD_BIT  = 6,
  parameter int ADDR_LSB = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [31:0]     va,
  input  logic            is_write,
  input  logic [31:0]     root_ptr,
  input  logic [CTXW-1:0] ctx_num,
  input  logic            perm_ok,
  output logic            mem_req,
  output logic            mem_we,
  output logic [PAW-1:0]  mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic            mem_ack,
  input  logic            mem_err,
  input  logic [31:0]     mem_rdata,
  output logic            busy,
  output logic            done,
  output logic [PAW-1:0]  pa,
  output logic [1:0]      leaf_lvl,
  output logic [2:0]      leaf_perm,
  output logic [9:0]      fault
);

  localparam int PA_SH = ADDR_LSB + 4;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_CHK, S_WB} st_t;

  st_t         st;
  logic [1:0]  lvl;
  logic [31:0] va_q;
  logic        wr_q;
  logic [31:0] desc_q;

  logic [7:0]     idx;
  logic [PAW-1:0] next_addr;
  logic [11:0]    off;
  logic [PAW-1:0] pa_calc;
  logic [2:0]     f_type;
  logic           descend, is_leaf, need_wb;

  always_comb begin
    case (lvl)
      2'd0:    idx = va_q[31:24];
      2'd1:    idx = {2'b00, va_q[23:18]};
      default: idx = {2'b00, va_q[17:12]};
    endcase
  end

  assign next_addr = (PAW'({mem_rdata[31:2], 2'b00}) << 4) + (PAW'(idx) << 2);

  always_comb begin
    case (lvl)
      2'd1:    off = va_q[23:12];
      2'd2:    off = {6'b0, va_q[17:12]};
      default: off = 12'd0;
    endcase
  end

  assign pa_calc   = (PAW'(desc_q[31:ADDR_LSB]) << PA_SH) + (PAW'(off) << 12);
  assign leaf_perm = desc_q[4:2];
  assign need_wb   = !desc_q[ACC_BIT] || (wr_q && !desc_q[MOD_BIT]);

  always_comb begin
    f_type  = 3'd0;
    descend = 1'b0;
    is_leaf = 1'b0;
    if (mem_err) f_type = 3'd4;
    else begin
      case (mem_rdata[1:0])
        2'd0: f_type = 3'd1;
        2'd1: if (lvl == 2'd3) f_type = 3'd4; else descend = 1'b1;
        2'd2: if (lvl == 2'd0) f_type = 3'd4; else is_leaf = 1'b1;
        default: f_type = 3'd4;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      lvl       <= 2'd0;
      va_q      <= '0;
      wr_q      <= 1'b0;
      desc_q    <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      pa        <= '0;
      leaf_lvl  <= 2'd0;
      fault     <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          busy     <= 1'b1;
          va_q     <= va;
          wr_q     <= is_write;
          lvl      <= 2'd0;
          mem_addr <= (PAW'(root_ptr) << 4) + (PAW'(ctx_num) << 2);
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          st       <= S_RD;
        end
        S_RD: if (mem_ack) begin
          mem_req <= 1'b0;
          if (descend) begin
            lvl      <= lvl + 2'd1;
            mem_addr <= next_addr;
            mem_req  <= 1'b1;
          end else if (is_leaf) begin
            desc_q <= mem_rdata;
            st     <= S_CHK;
          end else begin
            fault <= {lvl, 3'b000, f_type, 2'b00};
            done  <= 1'b1;
            busy  <= 1'b0;
            st    <= S_IDLE;
          end
        end
        S_CHK: begin
          pa       <= pa_calc;
          leaf_lvl <= lvl;
          fault    <= '0;
          if (perm_ok && need_wb) begin
            mem_wdata <= desc_q | (32'd1 << ACC_BIT) | (wr_q ? (32'd1 << MOD_BIT) : 32'd0);
            mem_we    <= 1'b1;
            mem_req   <= 1'b1;
            st        <= S_WB;
          end else begin
            done <= 1'b1;
            busy <= 1'b0;
            st   <= S_IDLE;
          end
        end
        S_WB: if (mem_ack) begin
          mem_req <= 1'b0;
          mem_we  <= 1'b0;
          done    <= 1'b1;
          busy    <= 1'b0;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  p_wb_same_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $stable(mem_addr));

  p_wb_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[ACC_BIT] && (mem_wdata[MOD_BIT] || !wr_q));

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !mem_req);

  p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  p_fault_fmt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done && (fault != 10'd0) |-> (fault[1:0] == 2'd0) && (fault[7:5] == 3'd0)
                                 && (fault[4:2] == 3'd1 || fault[4:2] == 3'd4));

endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PAW = 36;

  logic clk = 0, rst_n = 0;
  logic start = 0, is_write = 0, perm_ok = 0;
  logic [31:0] va = 0, root_ptr = 0;
  logic [7:0] ctx_num = 0;
  logic mem_req, mem_we, mem_ack, mem_err;
  logic [PAW-1:0] mem_addr, pa;
  logic [31:0] mem_wdata, mem_rdata;
  logic busy, done;
  logic [1:0] leaf_lvl;
  logic [2:0] leaf_perm;
  logic [9:0] fault;

  int n_tests = 0, n_fail = 0;
  logic [31:0] mem [logic [PAW-1:0]];
  logic [PAW-1:0] err_addr = '1;
  logic [PAW-1:0] rd_log [8];
  int rd_cnt = 0, wr_cnt = 0, done_cnt = 0;
  logic [PAW-1:0] wr_addr;
  logic [31:0] wr_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_walker u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .va(va), .is_write(is_write),
    .root_ptr(root_ptr), .ctx_num(ctx_num), .perm_ok(perm_ok),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .pa(pa), .leaf_lvl(leaf_lvl),
    .leaf_perm(leaf_perm), .fault(fault));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 0; mem_err <= 0; mem_rdata <= 0;
    end else begin
      mem_ack <= 0; mem_err <= 0;
      if (done) done_cnt = done_cnt + 1;
      if (mem_req && !mem_ack) begin
        mem_ack <= 1;
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          wr_cnt = wr_cnt + 1; wr_addr = mem_addr; wr_data = mem_wdata;
        end else begin
          mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
          mem_err <= (mem_addr == err_addr);
          if (rd_cnt < 8) rd_log[rd_cnt] = mem_addr;
          rd_cnt = rd_cnt + 1;
        end
      end
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [PAW-1:0] tbl(logic [31:0] d, logic [7:0] i);
    return (PAW'({d[31:2], 2'b00}) << 4) + (PAW'(i) << 2);
  endfunction

  function automatic logic [PAW-1:0] exp_pa(logic [31:0] d, logic [31:0] v, int l);
    logic [PAW-1:0] o;
    o = (l == 1) ? (PAW'(v[23:12]) << 12) : (l == 2) ? (PAW'(v[17:12]) << 12) : '0;
    return (PAW'(d[31:8]) << 12) + o;
  endfunction

  localparam logic [31:0] CTXD = 32'h0000_2001, L1D = 32'h0000_3001, L2D = 32'h0000_4001;
  localparam logic [31:0] VA_A = 32'h1234_5678;
  localparam logic [31:0] LEAF_A = 32'h0ABC_DE0E;

  task automatic build();
    mem.delete();
    err_addr = '1;
    root_ptr = 32'h1000; ctx_num = 8'd3;
    mem[(PAW'(32'h1000) << 4) + (PAW'(3) << 2)] = CTXD;
    mem[tbl(CTXD, VA_A[31:24])] = L1D;
    mem[tbl(L1D, {2'b0, VA_A[23:18]})] = L2D;
    mem[tbl(L2D, {2'b0, VA_A[17:12]})] = LEAF_A;
  endtask

  task automatic walk(logic [31:0] v, logic w, logic pk);
    int t;
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0; done_cnt = 0;
    va = v; is_write = w; perm_ok = pk; start = 1;
    @(negedge clk);
    start = 0;
    t = 0;
    while (!done && t < 200) begin @(negedge clk); t++; end
    if (t >= 200) chk("R10 walk timeout", 1, 0);
  endtask

  task automatic t_reset();
    chk("R10 reset busy", busy, 0);
    chk("R10 reset done", done, 0);
    chk("R9 reset req", mem_req, 0);
  endtask

  task automatic t_l3_read();
    build();
    walk(VA_A, 0, 1);
    chk("R1 ctx addr", rd_log[0], (PAW'(32'h1000) << 4) + 12);
    chk("R2 l1 addr", rd_log[1], tbl(CTXD, VA_A[31:24]));
    chk("R2 l2 addr", rd_log[2], tbl(L1D, {2'b0, VA_A[23:18]}));
    chk("R2 l3 addr", rd_log[3], tbl(L2D, {2'b0, VA_A[17:12]}));
    chk("R9 read count", rd_cnt, 4);
    chk("R3 pa l3", pa, exp_pa(LEAF_A, VA_A, 3));
    chk("R3 lvl l3", leaf_lvl, 3);
    chk("R3 fault zero", fault, 0);
    chk("R11 perm", leaf_perm, LEAF_A[4:2]);
    chk("R7 wb count", wr_cnt, 1);
    chk("R7 wb addr", wr_addr, rd_log[3]);
    chk("R7 wb data rd", wr_data, LEAF_A | 32'h20);
  endtask

  task automatic t_l3_write();
    walk(VA_A, 1, 1);
    chk("R7 wb count wr", wr_cnt, 1);
    chk("R7 wb data wr", wr_data, LEAF_A | 32'h60);
    walk(VA_A, 1, 1);
    chk("R8 no wb flags set", wr_cnt, 0);
    chk("R8 leaf unchanged", mem[rd_log[3]], LEAF_A | 32'h60);
  endtask

  task automatic t_perm_denied();
    build();
    walk(VA_A, 1, 0);
    chk("R8 no wb perm low", wr_cnt, 0);
    chk("R8 leaf untouched", mem[tbl(L2D, {2'b0, VA_A[17:12]})], LEAF_A);
    chk("R3 pa perm low", pa, exp_pa(LEAF_A, VA_A, 3));
  endtask

  task automatic t_l1_leaf();
    logic [31:0] v, d;
    build();
    v = 32'h56AB_C123; d = 32'h0012_3472;
    mem[tbl(CTXD, v[31:24])] = d;
    walk(v, 0, 1);
    chk("R3 pa l1", pa, exp_pa(d, v, 1));
    chk("R3 lvl l1", leaf_lvl, 1);
    chk("R11 perm l1", leaf_perm, 3'b100);
    chk("R8 no wb l1", wr_cnt, 0);
    chk("R9 reads l1", rd_cnt, 2);
  endtask

  task automatic t_l2_leaf();
    logic [31:0] v, d;
    build();
    v = 32'h12C8_7000; d = 32'h0055_5516;
    mem[tbl(L1D, {2'b0, v[23:18]})] = d;
    walk(v, 1, 1);
    chk("R3 pa l2", pa, exp_pa(d, v, 2));
    chk("R3 lvl l2", leaf_lvl, 2);
    chk("R7 wb l2", wr_data, d | 32'h60);
    chk("R7 wb addr l2", wr_addr, tbl(L1D, {2'b0, v[23:18]}));
  endtask

  task automatic t_faults();
    build();
    walk(32'h12FC_0000, 0, 1);
    chk("R4 invalid l2", fault, 10'h204);
    build();
    mem[tbl(CTXD, 8'h77)] = 32'h3;
    walk(32'h7700_0000, 0, 1);
    chk("R5 reserved l1", fault, 10'h110);
    build();
    ctx_num = 8'd5;
    mem[(PAW'(32'h1000) << 4) + 20] = 32'h0000_0102;
    walk(VA_A, 0, 1);
    chk("R5 leaf in ctx", fault, 10'h010);
    build();
    mem[tbl(L2D, 8'd6)] = 32'h5001;
    walk(32'h1234_6000, 0, 1);
    chk("R5 pointer at l3", fault, 10'h310);
    chk("R8 no wb on fault", wr_cnt, 0);
  endtask

  task automatic t_bus_err();
    build();
    err_addr = tbl(L2D, {2'b0, VA_A[17:12]});
    walk(VA_A, 0, 1);
    chk("R6 bus err l3", fault, 10'h310);
    build();
    err_addr = (PAW'(32'h1000) << 4) + 12;
    walk(VA_A, 0, 1);
    chk("R6 bus err l0", fault, 10'h010);
    chk("R6 reads stop", rd_cnt, 1);
  endtask

  task automatic t_start_busy();
    int t;
    build();
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0; done_cnt = 0;
    va = VA_A; is_write = 0; perm_ok = 1; start = 1;
    @(negedge clk);
    chk("R10 busy after start", busy, 1);
    va = 32'h56AB_C000; start = 1;
    @(negedge clk);
    @(negedge clk);
    start = 0;
    t = 0;
    while (!done && t < 200) begin @(negedge clk); t++; end
    chk("R10 busy low at done", busy, 0);
    repeat (5) @(negedge clk);
    chk("R10 one done", done_cnt, 1);
    chk("R10 start ignored", rd_cnt, 4);
    chk("R10 va held", pa, exp_pa(LEAF_A, VA_A, 3));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_l3_read();
    t_l3_write();
    t_perm_denied();
    t_l1_leaf();
    t_l2_leaf();
    t_faults();
    t_bus_err();
    t_start_busy();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R10 watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule